// File: doc/BRIEF.md
# Cipher Engine Configuration Register

This block is the single software-visible control word of a block-cipher accelerator. Software writes one 32-bit word that sets the enable, the operating mode, the chaining mode, the authenticated-mode phase, the data-swap type, the key size, the two DMA request enables and the count of padding bytes in the final block. The register turns that word into configuration fields for the cipher core. It also enforces when a write may change those fields.

The core supplies a busy level, a key-valid level and two completion strobes. One strobe marks the end of key preparation and the other marks the end of the authenticated-mode initialization phase. The enable bit clears itself on either completion. It cannot be set without a valid key, and each time it goes from off to on the core receives a one-cycle reinitialize pulse. A software-reset bit holds every other field at zero while it is set. The bit keeps its own value until software clears it.

Word layout: enable bit 0, mode [2:1], chaining [5:3], phase [7:6], swap type [9:8], key size bit 10, DMA input enable bit 11, DMA output enable bit 12, pad count [16:13], software reset bit 31. All other bits read as zero.

Top module: `crypto_ctrl_reg`

## Requirements
- R1: After reset every field is zero, `rd_data` reads 0, and `reinit`, `chain_err` and `soft_rst` are low.
- R2: When a write is accepted, each field is stored at its bit position and read back on `rd_data` the next cycle. Mode codes: 0 encrypt, 1 key derivation, 2 decrypt. Chaining codes: 0 ECB, 1 CBC, 2 CTR, 3 authenticated (GCM). Swap codes: 0 none, 1 half-word, 2 byte, 3 bit. Key size: 0 for 128-bit, 1 for 256-bit.
- R3: While `busy` is 1, a write leaves mode, chaining, swap type and key size unchanged. Phase, pad count and the DMA enables are still written.
- R4: If enable is 1 before a write and the written bit 0 is 1, the write leaves mode, chaining, swap type and key size unchanged. If the written bit 0 is 0, the same write updates them.
- R5: A write with bit 0 at 1 sets enable only when `key_valid` is 1. Otherwise enable becomes 0.
- R6: A `prep_done` pulse while the stored mode is 1 clears enable on the next edge. This takes priority over a write in the same cycle.
- R7: An `init_done` pulse while chaining is 3 and phase is 0 clears enable on the next edge. With any other chaining or phase, `init_done` has no effect.
- R8: A DMA enable bit is stored as 0 whenever the mode that results from the same write is 1 (key derivation).
- R9: While the software-reset bit (bit 31) is set, all other fields and enable read as zero and writes to them have no effect. The bit itself reads back as written, and `soft_rst` follows it.
- R10: `chain_err` is 1 exactly when the stored chaining code is 4 to 7. Such codes are still stored.
- R11: `reinit` is high for exactly one cycle, in the first cycle enable reads 1 after having been 0.
- R12: `auth_phase` equals the stored phase when chaining is 3 and is 0 otherwise. The stored phase is still read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Write strobe for the configuration word |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current configuration word |
| busy | input | 1 | Core is processing |
| key_valid | input | 1 | Key registers hold a valid key |
| prep_done | input | 1 | Key preparation finished (pulse) |
| init_done | input | 1 | Authenticated-mode init phase finished (pulse) |
| cfg_en | output | 1 | Enable |
| cfg_mode | output | 2 | Operating mode |
| cfg_chain | output | 3 | Chaining mode |
| auth_phase | output | 2 | Effective authenticated-mode phase |
| cfg_swap | output | 2 | Data-swap type |
| cfg_key256 | output | 1 | 256-bit key selected |
| cfg_dma_in | output | 1 | DMA input requests enabled |
| cfg_dma_out | output | 1 | DMA output requests enabled |
| cfg_pad | output | 4 | Padding bytes in last block |
| chain_err | output | 1 | Reserved chaining code stored |
| reinit | output | 1 | One-cycle reinitialize pulse to the core |
| soft_rst | output | 1 | Software reset held |

## Verification
The hardest case to reach is a collision: a completion strobe, a write and a lock condition all in one cycle, such as `prep_done` arriving in the same cycle as a write that tries to keep enable set while `busy` is high. Directed sequences first lead the register into key-derivation and authenticated-init states and fire each strobe on its own. A long random phase then drives `busy`, `key_valid`, both strobes and writes with independent probabilities, and a rare software-reset bit, so these overlaps happen many times. A behavioural model in the bench checks every clock.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  localparam int PAD_W   = 4;
  localparam int MODE_W  = 2;
  localparam int CHAIN_W = 3;
  localparam int PHASE_W = 2;
  localparam int SWAP_W  = 2;

  // bit positions inside the configuration word
  localparam int B_EN    = 0;
  localparam int B_MODE  = 1;
  localparam int B_CHAIN = B_MODE + MODE_W;
  localparam int B_PHASE = B_CHAIN + CHAIN_W;
  localparam int B_SWAP  = B_PHASE + PHASE_W;
  localparam int B_KSIZE = B_SWAP + SWAP_W;
  localparam int B_DIN   = B_KSIZE + 1;
  localparam int B_DOUT  = B_DIN + 1;
  localparam int B_PAD   = B_DOUT + 1;
  localparam int B_TOP   = B_PAD + PAD_W;
  localparam int B_SRST  = 31;

  localparam logic [MODE_W-1:0]  MODE_KDER  = 2'd1;
  localparam logic [CHAIN_W-1:0] CHAIN_AUTH = 3'd3;
  localparam logic [PHASE_W-1:0] PHASE_INIT = 2'd0;

  typedef struct packed {
    logic [PAD_W-1:0]   pad;
    logic               dma_out;
    logic               dma_in;
    logic               key256;
    logic [SWAP_W-1:0]  swap;
    logic [PHASE_W-1:0] phase;
    logic [CHAIN_W-1:0] chain;
    logic [MODE_W-1:0]  mode;
  } cfg_t;
endpackage

// File: rtl/ccr_rst_sync.sv
module ccr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/ccr_write_gate.sv
module ccr_write_gate (
  input  logic busy,
  input  logic en_q,
  input  logic wr_en_bit,
  output logic lock_ok
);
  // locked fields accept a write only when idle and not held enabled
  always_comb begin
    lock_ok = 1'b1;
    if (busy)                lock_ok = 1'b0;
    if (en_q && wr_en_bit)   lock_ok = 1'b0;
  end
endmodule

// File: rtl/ccr_enable_ctrl.sv
module ccr_enable_ctrl
  import ccr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               wr_en_bit,
  input  logic               key_valid,
  input  logic               srst_d,
  input  logic               prep_done,
  input  logic               init_done,
  input  logic [MODE_W-1:0]  mode_q,
  input  logic [CHAIN_W-1:0] chain_q,
  input  logic [PHASE_W-1:0] phase_q,
  output logic               en_q,
  output logic               reinit_q
);
  logic en_d, reinit_d, hw_clear, step;

  always_comb begin
    hw_clear = (prep_done && mode_q == MODE_KDER) ||
               (init_done && chain_q == CHAIN_AUTH && phase_q == PHASE_INIT);
    en_d = en_q;
    if (srst_d)        en_d = 1'b0;
    else if (hw_clear) en_d = 1'b0;
    else if (wr_en)    en_d = wr_en_bit & key_valid;
    reinit_d = en_d & ~en_q;
    step     = (en_d != en_q) || reinit_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      reinit_q <= 1'b0;
    end else if (step) begin
      en_q     <= en_d;
      reinit_q <= reinit_d;
    end
  end
endmodule

// File: rtl/crypto_ctrl_reg.sv
module crypto_ctrl_reg
  import ccr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [DATA_W-1:0]  wr_data,
  output logic [DATA_W-1:0]  rd_data,
  input  logic               busy,
  input  logic               key_valid,
  input  logic               prep_done,
  input  logic               init_done,
  output logic               cfg_en,
  output logic [MODE_W-1:0]  cfg_mode,
  output logic [CHAIN_W-1:0] cfg_chain,
  output logic [PHASE_W-1:0] auth_phase,
  output logic [SWAP_W-1:0]  cfg_swap,
  output logic               cfg_key256,
  output logic               cfg_dma_in,
  output logic               cfg_dma_out,
  output logic [PAD_W-1:0]   cfg_pad,
  output logic               chain_err,
  output logic               reinit,
  output logic               soft_rst
);
  logic rst_i_n, lock_ok, srst_q, srst_d, en_q, reinit_q;
  cfg_t cfg_q, cfg_d;
  logic unused_wr_bits;

  assign unused_wr_bits = ^wr_data[B_SRST-1:B_TOP];

  ccr_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  ccr_write_gate i_gate (
    .busy(busy), .en_q(en_q), .wr_en_bit(wr_data[B_EN]), .lock_ok(lock_ok)
  );

  ccr_enable_ctrl i_en (
    .clk(clk), .rst_n(rst_i_n), .wr_en(wr_en), .wr_en_bit(wr_data[B_EN]),
    .key_valid(key_valid), .srst_d(srst_d), .prep_done(prep_done),
    .init_done(init_done), .mode_q(cfg_q.mode), .chain_q(cfg_q.chain),
    .phase_q(cfg_q.phase), .en_q(en_q), .reinit_q(reinit_q)
  );

  // next-state of the stored fields
  always_comb begin
    cfg_d  = cfg_q;
    srst_d = srst_q;
    if (wr_en) begin
      srst_d = wr_data[B_SRST];
      if (lock_ok) begin
        cfg_d.mode   = wr_data[B_MODE  +: MODE_W];
        cfg_d.chain  = wr_data[B_CHAIN +: CHAIN_W];
        cfg_d.swap   = wr_data[B_SWAP  +: SWAP_W];
        cfg_d.key256 = wr_data[B_KSIZE];
      end
      cfg_d.phase   = wr_data[B_PHASE +: PHASE_W];
      cfg_d.pad     = wr_data[B_PAD   +: PAD_W];
      cfg_d.dma_in  = wr_data[B_DIN]  && (cfg_d.mode != MODE_KDER);
      cfg_d.dma_out = wr_data[B_DOUT] && (cfg_d.mode != MODE_KDER);
    end
    if (srst_d) cfg_d = '0;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      cfg_q  <= '0;
      srst_q <= 1'b0;
    end else if (wr_en) begin
      cfg_q  <= cfg_d;
      srst_q <= srst_d;
    end
  end

  always_comb begin
    rd_data                      = '0;
    rd_data[B_EN]                = en_q;
    rd_data[B_MODE  +: MODE_W]   = cfg_q.mode;
    rd_data[B_CHAIN +: CHAIN_W]  = cfg_q.chain;
    rd_data[B_PHASE +: PHASE_W]  = cfg_q.phase;
    rd_data[B_SWAP  +: SWAP_W]   = cfg_q.swap;
    rd_data[B_KSIZE]             = cfg_q.key256;
    rd_data[B_DIN]               = cfg_q.dma_in;
    rd_data[B_DOUT]              = cfg_q.dma_out;
    rd_data[B_PAD   +: PAD_W]    = cfg_q.pad;
    rd_data[B_SRST]              = srst_q;
  end

  assign cfg_en      = en_q;
  assign cfg_mode    = cfg_q.mode;
  assign cfg_chain   = cfg_q.chain;
  assign auth_phase  = (cfg_q.chain == CHAIN_AUTH) ? cfg_q.phase : PHASE_INIT;
  assign cfg_swap    = cfg_q.swap;
  assign cfg_key256  = cfg_q.key256;
  assign cfg_dma_in  = cfg_q.dma_in;
  assign cfg_dma_out = cfg_q.dma_out;
  assign cfg_pad     = cfg_q.pad;
  assign chain_err   = cfg_q.chain[CHAIN_W-1];
  assign reinit      = reinit_q;
  assign soft_rst    = srst_q;
endmodule

// File: rtl/ccr_checker.sv
module ccr_checker
  import ccr_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [31:0]        wr_data,
  input logic               busy,
  input logic               key_valid,
  input logic               prep_done,
  input logic               init_done,
  input logic               cfg_en,
  input logic [MODE_W-1:0]  cfg_mode,
  input logic [CHAIN_W-1:0] cfg_chain,
  input logic [PHASE_W-1:0] auth_phase,
  input logic [SWAP_W-1:0]  cfg_swap,
  input logic               cfg_key256,
  input logic               cfg_dma_in,
  input logic               cfg_dma_out,
  input logic [PAD_W-1:0]   cfg_pad,
  input logic               reinit,
  input logic               soft_rst
);
  assert_busy_lock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(wr_en && wr_data[B_SRST])) |=>
      ($stable(cfg_mode) && $stable(cfg_chain) && $stable(cfg_swap) && $stable(cfg_key256)));

  assert_en_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && wr_en && wr_data[B_EN] && !wr_data[B_SRST]) |=>
      ($stable(cfg_mode) && $stable(cfg_chain) && $stable(cfg_swap) && $stable(cfg_key256)));

  assert_en_needs_key_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_en) |-> ($past(key_valid) && $past(wr_en)));

  assert_prep_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (prep_done && cfg_mode == MODE_KDER) |=> !cfg_en);

  assert_init_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && cfg_chain == CHAIN_AUTH && auth_phase == PHASE_INIT) |=> !cfg_en);

  assert_dma_kder_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == MODE_KDER) |-> (!cfg_dma_in && !cfg_dma_out));

  assert_srst_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> (!cfg_en && cfg_mode == '0 && cfg_chain == '0 && cfg_swap == '0 &&
                  !cfg_key256 && cfg_pad == '0 && !cfg_dma_in && !cfg_dma_out));

  assert_reinit_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    reinit |=> !reinit);

  assert_reinit_with_en_R11: assert property (@(posedge clk) disable iff (!rst_n)
    reinit |-> cfg_en);
endmodule

bind crypto_ctrl_reg ccr_checker i_ccr_checker (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .busy(busy),
  .key_valid(key_valid), .prep_done(prep_done), .init_done(init_done),
  .cfg_en(cfg_en), .cfg_mode(cfg_mode), .cfg_chain(cfg_chain),
  .auth_phase(auth_phase), .cfg_swap(cfg_swap), .cfg_key256(cfg_key256),
  .cfg_dma_in(cfg_dma_in), .cfg_dma_out(cfg_dma_out), .cfg_pad(cfg_pad),
  .reinit(reinit), .soft_rst(soft_rst)
);

// File: tb/test_crypto_ctrl_reg.sv
`timescale 1ns/1ps
module test_crypto_ctrl_reg;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, busy, key_valid, prep_done, init_done;
  logic [31:0] wr_data, rd_data;
  logic        cfg_en, cfg_key256, cfg_dma_in, cfg_dma_out, chain_err, reinit, soft_rst;
  logic [1:0]  cfg_mode, auth_phase, cfg_swap;
  logic [2:0]  cfg_chain;
  logic [3:0]  cfg_pad;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  crypto_ctrl_reg i_crypto_ctrl_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .busy(busy), .key_valid(key_valid), .prep_done(prep_done), .init_done(init_done),
    .cfg_en(cfg_en), .cfg_mode(cfg_mode), .cfg_chain(cfg_chain), .auth_phase(auth_phase),
    .cfg_swap(cfg_swap), .cfg_key256(cfg_key256), .cfg_dma_in(cfg_dma_in),
    .cfg_dma_out(cfg_dma_out), .cfg_pad(cfg_pad), .chain_err(chain_err),
    .reinit(reinit), .soft_rst(soft_rst)
  );

  // behavioural reference model
  int m_en, m_mode, m_chain, m_phase, m_swap, m_k256, m_din, m_dout, m_pad, m_srst, m_reinit;
  int sync_cnt;

  function automatic void m_clear();
    m_en = 0; m_mode = 0; m_chain = 0; m_phase = 0; m_swap = 0; m_k256 = 0;
    m_din = 0; m_dout = 0; m_pad = 0; m_srst = 0; m_reinit = 0;
  endfunction

  function automatic logic [31:0] m_word();
    logic [31:0] w = '0;
    w[0] = m_en[0]; w[2:1] = m_mode[1:0]; w[5:3] = m_chain[2:0]; w[7:6] = m_phase[1:0];
    w[9:8] = m_swap[1:0]; w[10] = m_k256[0]; w[11] = m_din[0]; w[12] = m_dout[0];
    w[16:13] = m_pad[3:0]; w[31] = m_srst[0];
    return w;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_clear(); sync_cnt = 0;
    end else if (sync_cnt < 2) begin
      sync_cnt++; m_clear();
    end else begin
      bit hw, nsrst, lock_ok, old_en, new_en;
      int wd;
      wd = wr_data;
      hw = (prep_done && m_mode == 1) || (init_done && m_chain == 3 && m_phase == 0);
      nsrst = wr_en ? wr_data[31] : m_srst[0];
      old_en = m_en[0];
      if (wr_en) begin
        lock_ok = !busy && !(m_en != 0 && wr_data[0]);
        if (lock_ok) begin
          m_mode = (wd >> 1) & 3; m_chain = (wd >> 3) & 7;
          m_swap = (wd >> 8) & 3; m_k256 = (wd >> 10) & 1;
        end
        m_phase = (wd >> 6) & 3; m_pad = (wd >> 13) & 15;
        m_din  = (m_mode != 1) ? ((wd >> 11) & 1) : 0;
        m_dout = (m_mode != 1) ? ((wd >> 12) & 1) : 0;
      end
      if (nsrst) begin
        m_mode = 0; m_chain = 0; m_phase = 0; m_swap = 0; m_k256 = 0;
        m_din = 0; m_dout = 0; m_pad = 0;
      end
      if (nsrst)      new_en = 0;
      else if (hw)    new_en = 0;
      else if (wr_en) new_en = wr_data[0] && key_valid;
      else            new_en = old_en;
      m_reinit = (new_en && !old_en) ? 1 : 0;
      m_en = new_en; m_srst = nsrst;
    end
    #1;
    if (rst_n) begin
      check("R2 word", rd_data, m_word());
      check("R11 reinit", {31'b0, reinit}, m_reinit);
      check("R10 chain_err", {31'b0, chain_err}, (m_chain >= 4) ? 1 : 0);
      check("R12 auth_phase", {30'b0, auth_phase}, (m_chain == 3) ? m_phase : 0);
      check("R9 soft_rst", {31'b0, soft_rst}, m_srst);
    end
  end

  function automatic logic [31:0] word(int en, int mode, int chain, int phase, int swap,
                                       int k256, int din, int dout, int pad, int srst);
    return (en & 1) | ((mode & 3) << 1) | ((chain & 7) << 3) | ((phase & 3) << 6) |
           ((swap & 3) << 8) | ((k256 & 1) << 10) | ((din & 1) << 11) |
           ((dout & 1) << 12) | ((pad & 15) << 13) | ((srst & 1) << 31);
  endfunction

  task automatic wr(logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse_prep();
    @(negedge clk); prep_done = 1'b1;
    @(negedge clk); prep_done = 1'b0;
  endtask

  task automatic pulse_init();
    @(negedge clk); init_done = 1'b1;
    @(negedge clk); init_done = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 0; wr_data = 0; busy = 0; key_valid = 0; prep_done = 0; init_done = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    check("R1 rd_data", rd_data, 32'h0);
    check("R1 outputs", {29'b0, reinit, chain_err, soft_rst}, 0);

    // R2: encodings and positions
    wr(word(0, 2, 1, 1, 2, 1, 1, 0, 5, 0));
    check("R2 readback", rd_data, word(0, 2, 1, 1, 2, 1, 1, 0, 5, 0));
    check("R2 cfg_mode decrypt", cfg_mode, 2);

    // R3: busy lock
    busy = 1;
    wr(word(0, 0, 2, 2, 1, 0, 0, 1, 9, 0));
    check("R3 locked under busy", rd_data, word(0, 2, 1, 2, 2, 1, 0, 1, 9, 0));
    busy = 0;

    // R5: enable needs key
    key_valid = 0;
    wr(word(1, 0, 0, 0, 0, 0, 0, 0, 0, 0));
    check("R5 no key", cfg_en, 0);
    key_valid = 1;
    wr(word(1, 0, 0, 0, 0, 0, 0, 0, 0, 0));
    check("R5 with key", cfg_en, 1);
    check("R11 pulse high", reinit, 1);
    @(negedge clk);
    check("R11 pulse gone", reinit, 0);

    // R4: lock while enabled unless clearing
    wr(word(1, 2, 2, 0, 3, 1, 0, 0, 0, 0));
    check("R4 locked while enabled", rd_data, word(1, 0, 0, 0, 0, 0, 0, 0, 0, 0));
    wr(word(0, 2, 2, 0, 3, 1, 0, 0, 0, 0));
    check("R4 clearing write accepted", rd_data, word(0, 2, 2, 0, 3, 1, 0, 0, 0, 0));

    // R8: DMA forced off in key derivation
    wr(word(0, 1, 0, 0, 0, 0, 1, 1, 0, 0));
    check("R8 dma blocked", {cfg_dma_in, cfg_dma_out}, 0);
    wr(word(0, 0, 0, 0, 0, 0, 1, 1, 0, 0));
    check("R8 dma allowed", {cfg_dma_in, cfg_dma_out}, 3);

    // R6: key preparation completion
    wr(word(0, 1, 1, 0, 0, 0, 0, 0, 0, 0));
    wr(word(1, 1, 1, 0, 0, 0, 0, 0, 0, 0));
    check("R6 enabled before", cfg_en, 1);
    pulse_prep();
    check("R6 cleared after prep", cfg_en, 0);

    // R7: authenticated init completion
    wr(word(0, 0, 3, 1, 0, 0, 0, 0, 0, 0));
    wr(word(1, 0, 3, 1, 0, 0, 0, 0, 0, 0));
    pulse_init();
    check("R7 phase 1 kept", cfg_en, 1);
    check("R12 auth phase shown", auth_phase, 1);
    wr(word(1, 0, 3, 0, 0, 0, 0, 0, 0, 0));
    pulse_init();
    check("R7 cleared at init", cfg_en, 0);
    wr(word(0, 0, 1, 2, 0, 0, 0, 0, 0, 0));
    check("R12 masked", auth_phase, 0);
    check("R12 stored phase", rd_data[7:6], 2);

    // R10: reserved chaining
    wr(word(0, 0, 5, 0, 0, 0, 0, 0, 0, 0));
    check("R10 flag", chain_err, 1);
    check("R10 stored", cfg_chain, 5);

    // R9: software reset
    wr(word(0, 2, 2, 1, 1, 1, 1, 1, 7, 0));
    wr(word(1, 2, 2, 1, 1, 1, 1, 1, 7, 1));
    check("R9 held zero", rd_data, 32'h8000_0000);
    wr(word(1, 2, 1, 1, 1, 1, 1, 1, 3, 1));
    check("R9 writes ignored", rd_data, 32'h8000_0000);
    wr(32'h0);
    check("R9 released", {soft_rst, rd_data[30:0]}, 0);

    // random collisions, checked every clock by the model
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      wr_en     = ($urandom % 3) == 0;
      wr_data   = $urandom & 32'h0001_FFFF;
      if (($urandom % 24) == 0) wr_data[31] = 1'b1;
      busy      = ($urandom % 4) == 0;
      key_valid = ($urandom % 4) != 0;
      prep_done = ($urandom % 6) == 0;
      init_done = ($urandom % 6) == 0;
    end
    @(negedge clk);
    wr_en = 0; prep_done = 0; init_done = 0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule